// File: doc/BRIEF.md
# Frame Address Filter

This block decides whether a received frame should be kept or dropped. The decision is based on the service access point value carried in the frame header. For each header it compares the 6-bit value against three fixed reference addresses: a signalling address (0), a packet address (16) and a group address (63). Three control bits then turn the comparison results into a verdict. The verdict is returned before the frame's payload would be written into a receive buffer, so downstream storage can use it to commit or discard the frame.

Two of the control bits pick which reference addresses form the "selected" set. The select-signalling bit adds addresses 0 and 16. The select-group bit adds addresses 63 and 16. The packet address therefore joins the set whenever either select bit is set. The polarity bit decides what the set means:
- With polarity 0, selected addresses are dropped and every other address is kept.
- With polarity 1, only selected addresses are kept.

An empty set gives keep-everything under polarity 0 and drop-everything under polarity 1.

Headers arrive on a valid/ready stream and verdicts leave on another. A header transfers on a clock edge where `hdr_valid` and `hdr_ready` are both high. The verdict for that header appears on the verdict stream one clock later. A verdict is held, unchanged, until the consumer takes it with `verdict_ready`. While a verdict is held and not taken, `hdr_ready` is low. The control bits are sampled together with the header, so a control change after the transfer does not alter a pending verdict.

Top module: `sap_filter`

## Requirements
- R1: After reset, `verdict_valid` is 0 and `hdr_ready` is 1.
- R2: With polarity 0 and neither select bit set, every address is kept (`verdict_accept` = 1).
- R3: With polarity 1 and neither select bit set, every address is dropped (`verdict_accept` = 0).
- R4: Setting the select-signalling bit places addresses 0 and 16 in the selected set.
- R5: Setting the select-group bit places addresses 63 and 16 in the selected set.
- R6: With polarity 0, an address in the selected set is dropped and any address outside it is kept.
- R7: With polarity 1, an address in the selected set is kept and any address outside it is dropped.
- R8: After a header transfer, `verdict_valid` is 1 in the following cycle. Without a transfer, a verdict that was taken (or none present) leaves `verdict_valid` at 0 in the following cycle.
- R9: While `verdict_valid` is 1 and `verdict_ready` is 0, the verdict stays valid and `verdict_accept` does not change.
- R10: `hdr_ready` is 0 whenever a verdict is held and `verdict_ready` is 0, and 1 when no verdict is held.
- R11: The control bits are captured at the header transfer; changing them afterwards does not change that header's verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid | input | 1 | Header address is present |
| hdr_ready | output | 1 | Block can take a header this cycle |
| hdr_sap | input | 6 | Service access point value of the header |
| ctl_polarity | input | 1 | 0: selected set is dropped; 1: selected set is kept |
| ctl_sel_grp | input | 1 | Select group address 63 (and 16) |
| ctl_sel_sig | input | 1 | Select signalling address 0 (and 16) |
| verdict_valid | output | 1 | A verdict is present |
| verdict_ready | input | 1 | Consumer takes the verdict this cycle |
| verdict_accept | output | 1 | 1 keeps the frame, 0 drops it |

## Verification
The bench walks all eight control settings against the three reference addresses and their immediate neighbours (1, 15, 17, 62) plus an unrelated value. This covers the two failure modes most likely in the decision logic:
- A design that left 16 out of the set, or added it when no select bit was set, would give the wrong verdict on address 16.
- A design with an inverted polarity would invert every non-empty case and swap keep-everything with drop-everything.

The verdict consumer stalls on a repeating pattern, and the control bits are scrambled after every transfer. A stage that overwrote a held verdict, dropped one, or evaluated with live rather than captured controls therefore shows as a mismatch or a stability failure. `hdr_ready` is checked low during every stall, which catches a design that accepts a header it has nowhere to put.

// File: rtl/sapf_pkg.sv
package sapf_pkg;

  // Control bits captured alongside each header.
  typedef struct packed {
    logic polarity;
    logic sel_grp;
    logic sel_sig;
  } sapf_ctl_t;

  localparam int unsigned NUM_REF = 3;
  localparam int unsigned IDX_SIG = 0;
  localparam int unsigned IDX_PKT = 1;
  localparam int unsigned IDX_GRP = 2;

  // Which reference addresses take part in the selected set.
  function automatic logic [NUM_REF-1:0] sel_mask(input sapf_ctl_t c);
    logic [NUM_REF-1:0] m;
    m          = '0;
    m[IDX_SIG] = c.sel_sig;
    m[IDX_PKT] = c.sel_sig | c.sel_grp;
    m[IDX_GRP] = c.sel_grp;
    return m;
  endfunction

endpackage

// File: rtl/sapf_match.sv
module sapf_match #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned SIG_ADDR = 0,
  parameter int unsigned PKT_ADDR = 16,
  parameter int unsigned GRP_ADDR = 63
) (
  input  logic [ADDR_W-1:0]             addr,
  output logic [sapf_pkg::NUM_REF-1:0]  hit
);
  import sapf_pkg::*;

  function automatic logic [ADDR_W-1:0] ref_of(input int unsigned idx);
    case (idx)
      IDX_SIG: return ADDR_W'(SIG_ADDR);
      IDX_PKT: return ADDR_W'(PKT_ADDR);
      default: return ADDR_W'(GRP_ADDR);
    endcase
  endfunction

  for (genvar i = 0; i < NUM_REF; i++) begin : g_cmp
    localparam logic [ADDR_W-1:0] REF = ref_of(i);
    assign hit[i] = (addr == REF);
  end

endmodule

// File: rtl/sapf_policy.sv
module sapf_policy (
  input  sapf_pkg::sapf_ctl_t           ctl,
  input  logic [sapf_pkg::NUM_REF-1:0]  hit,
  output logic                          accept
);
  import sapf_pkg::*;

  logic [NUM_REF-1:0] sel;
  logic               in_set;

  always_comb begin
    sel    = sel_mask(ctl);
    in_set = |(sel & hit);
    accept = ctl.polarity ? in_set : ~in_set;
  end

endmodule

// File: rtl/sapf_outreg.sv
module sapf_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_accept,
  output logic out_valid,
  input  logic out_ready,
  output logic out_accept
);

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_accept <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid  <= 1'b1;
      out_accept <= in_accept;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/sap_filter.sv
module sap_filter #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned SIG_ADDR = 0,
  parameter int unsigned PKT_ADDR = 16,
  parameter int unsigned GRP_ADDR = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [ADDR_W-1:0] hdr_sap,
  input  logic              ctl_polarity,
  input  logic              ctl_sel_grp,
  input  logic              ctl_sel_sig,
  output logic              verdict_valid,
  input  logic              verdict_ready,
  output logic              verdict_accept
);
  import sapf_pkg::*;

  sapf_ctl_t          ctl;
  logic [NUM_REF-1:0] hit;
  logic               accept_now;

  assign ctl = '{polarity: ctl_polarity, sel_grp: ctl_sel_grp, sel_sig: ctl_sel_sig};

  sapf_match #(
    .ADDR_W(ADDR_W), .SIG_ADDR(SIG_ADDR), .PKT_ADDR(PKT_ADDR), .GRP_ADDR(GRP_ADDR)
  ) u_match (
    .addr (hdr_sap),
    .hit  (hit)
  );

  sapf_policy u_policy (
    .ctl    (ctl),
    .hit    (hit),
    .accept (accept_now)
  );

  sapf_outreg u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (hdr_valid),
    .in_ready   (hdr_ready),
    .in_accept  (accept_now),
    .out_valid  (verdict_valid),
    .out_ready  (verdict_ready),
    .out_accept (verdict_accept)
  );

endmodule

// File: rtl/sap_filter_chk.sv
module sap_filter_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hdr_valid,
  input logic              hdr_ready,
  input logic [ADDR_W-1:0] hdr_sap,
  input logic              ctl_polarity,
  input logic              ctl_sel_grp,
  input logic              ctl_sel_sig,
  input logic              verdict_valid,
  input logic              verdict_ready,
  input logic              verdict_accept
);

  logic fire;
  assign fire = hdr_valid && hdr_ready;

  // R2
  keep_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !ctl_polarity && !ctl_sel_grp && !ctl_sel_sig |=> verdict_accept);

  // R3
  drop_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ctl_polarity && !ctl_sel_grp && !ctl_sel_sig |=> !verdict_accept);

  // R4
  sig_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ctl_sel_sig && (hdr_sap == ADDR_W'(16))
      |=> verdict_accept == $past(ctl_polarity));

  // R5
  grp_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ctl_sel_grp && (hdr_sap == ADDR_W'(63))
      |=> verdict_accept == $past(ctl_polarity));

  // R8
  verdict_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> verdict_valid);

  // R8
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire && (!verdict_valid || verdict_ready) |=> !verdict_valid);

  // R9
  hold_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid && !verdict_ready |=> verdict_valid && $stable(verdict_accept));

  // R10
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid && !verdict_ready |-> !hdr_ready);

  // R10
  empty_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> hdr_ready);

endmodule

bind sap_filter sap_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .hdr_valid      (hdr_valid),
  .hdr_ready      (hdr_ready),
  .hdr_sap        (hdr_sap),
  .ctl_polarity   (ctl_polarity),
  .ctl_sel_grp    (ctl_sel_grp),
  .ctl_sel_sig    (ctl_sel_sig),
  .verdict_valid  (verdict_valid),
  .verdict_ready  (verdict_ready),
  .verdict_accept (verdict_accept)
);

// File: tb/sap_filter_test.sv
`timescale 1ns/1ps
module sap_filter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hdr_valid = 1'b0;
  logic       hdr_ready;
  logic [5:0] hdr_sap = '0;
  logic       ctl_polarity = 1'b0;
  logic       ctl_sel_grp = 1'b0;
  logic       ctl_sel_sig = 1'b0;
  logic       verdict_valid;
  logic       verdict_ready = 1'b1;
  logic       verdict_accept;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit bp_on  = 1'b0;
  int cyc    = 0;

  logic  q_acc[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  sap_filter uut (
    .clk(clk), .rst_n(rst_n),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_sap(hdr_sap),
    .ctl_polarity(ctl_polarity), .ctl_sel_grp(ctl_sel_grp), .ctl_sel_sig(ctl_sel_sig),
    .verdict_valid(verdict_valid), .verdict_ready(verdict_ready),
    .verdict_accept(verdict_accept)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit model(input bit pol, input bit g, input bit s, input int a);
    bit in_set;
    in_set = (s && a == 0) || ((s || g) && a == 16) || (g && a == 63);
    return pol ? in_set : !in_set;
  endfunction

  function automatic string tag_of(input bit pol, input bit g, input bit s, input int a);
    if (!g && !s) return pol ? "R3" : "R2";
    if (a == 0 && s) return "R4";
    if (a == 63 && g) return "R5";
    if (a == 16) return s ? "R4" : "R5";
    return pol ? "R7" : "R6";
  endfunction

  // Driver: present one header, wait for the handshake, push the expectation.
  task automatic send(input bit pol, input bit g, input bit s, input int a);
    @(negedge clk);
    hdr_valid    = 1'b1;
    hdr_sap      = 6'(a);
    ctl_polarity = pol;
    ctl_sel_grp  = g;
    ctl_sel_sig  = s;
    #1;
    while (!hdr_ready) begin
      @(negedge clk);
      #1;
    end
    q_acc.push_back(model(pol, g, s, a));
    q_tag.push_back(tag_of(pol, g, s, a));
    @(posedge clk);
    #1;
    check(verdict_valid === 1'b1, "R8", verdict_valid, 1);
    // R11: scramble controls after capture
    ctl_polarity = ~pol;
    ctl_sel_grp  = ~g;
    ctl_sel_sig  = ~s;
  endtask

  // Consumer back-pressure pattern
  always @(negedge clk) begin
    cyc++;
    verdict_ready <= bp_on ? ((cyc % 3) != 1) : 1'b1;
  end

  // Monitor / scoreboard
  bit   stalled = 1'b0;
  logic held    = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && verdict_valid) begin
        if (stalled) check(verdict_accept === held, "R9", verdict_accept, held);
        if (!verdict_ready) begin
          check(hdr_ready === 1'b0, "R10", hdr_ready, 0);
          stalled = 1'b1;
          held    = verdict_accept;
        end else begin
          stalled = 1'b0;
          if (q_acc.size() == 0) begin
            check(1'b0, "R8 unexpected verdict", 1, 0);
          end else begin
            logic  e;
            string t;
            e = q_acc.pop_front();
            t = q_tag.pop_front();
            check(verdict_accept === e, {t, "/R11"}, verdict_accept, e);
          end
        end
      end else begin
        stalled = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int addrs[8] = '{0, 16, 63, 1, 15, 17, 62, 32};
    repeat (3) @(posedge clk);
    #1;
    check(verdict_valid === 1'b0, "R1 valid", verdict_valid, 0);
    check(hdr_ready === 1'b1, "R1 ready", hdr_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int pass = 0; pass < 2; pass++) begin
      bp_on = (pass == 1);
      for (int c = 0; c < 8; c++) begin
        for (int k = 0; k < 8; k++) begin
          send(c[2], c[1], c[0], addrs[k]);
        end
      end
    end
    @(negedge clk);
    hdr_valid = 1'b0;
    for (int w = 0; w < 50 && q_acc.size() != 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    #3;
    check(q_acc.size() == 0, "R8 drained", q_acc.size(), 0);
    check(verdict_valid === 1'b0, "R8 idle", verdict_valid, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule